// File: doc/BRIEF.md
# Two-Wire Command/Response Slave

This block is a serial slave that connects an external controller to an on-chip command engine over a two-pin bus: a clock line and a shared open-drain data line. A fast system clock oversamples both pins. The slave recognises START and STOP framing, matches a 7-bit device address plus a direction bit, and acknowledges or ignores the transfer according to that match. The data line is never driven high. The slave only asserts an output enable that pulls the line low.

In the write direction the slave collects a command opcode and up to seven argument bytes. After the closing STOP it presents them to the core with a one-cycle valid pulse. In the read direction it streams bytes from a response buffer that the core supplies. The first of those bytes is a status byte whose top bit is the clear-to-send flag. The controller polls that flag before it issues a command or collects a response. The core pulses a done input to raise the flag again. A strap input, sampled while reset is held, chooses one of two device addresses.

Top module: `twowire_cmd_slave`

## Requirements
- R1: A START is a high-to-low change of the data line while the clock is high, and a STOP is a low-to-high change while the clock is high. After a STOP the slave stops pulling the line and waits for the next START.
- R2: The first byte after START is the control byte, sent MSB first on clock rising edges. Its bits 7:1 are the device address and bit 0 is the direction, where 1 means read and 0 means write.
- R3: On an address match the slave pulls the data line low for the ninth clock period, starting at the eighth falling edge. On a mismatch it gives no acknowledge and does not pull the line again until the next START.
- R4: The address strap is sampled while reset is low. Low selects address 0x11 and high selects 0x63 (default parameters).
- R5: Each written byte is acknowledged. The first written byte is the opcode and appears on cmd_data[7:0]. Written byte i appears on cmd_data[8i+7:8i]. cmd_len gives the number of bytes kept.
- R6: Written bytes beyond the eighth are still acknowledged but are discarded. cmd_len then reads 8 and the first eight bytes are kept.
- R7: cmd_valid pulses for one cycle after a STOP that ends a write carrying at least one data byte. A write that carries only the control byte, or a transfer that is not addressed to this slave, produces no pulse.
- R8: In a read, bytes leave MSB first and the slave changes the line after clock falling edges. Byte 0 is {cts, rsp_data[6:0]}. Byte k, for 1 to 15, is rsp_data[8k+7:8k].
- R9: If the controller leaves the acknowledge bit after a read byte high (no acknowledge), the slave releases the line for the rest of the transfer.
- R10: Read bytes after the sixteenth return 0x00.
- R11: cts is 1 after reset. It falls in the cycle that cmd_valid pulses and rises again on a cmd_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset |
| addr_sel | input | 1 | Address strap, sampled while reset is low |
| scl_in | input | 1 | Bus clock pin as received |
| sda_in | input | 1 | Bus data pin as received |
| sda_oe | output | 1 | 1 pulls the data line low |
| cmd_valid | output | 1 | One-cycle pulse when a command is ready |
| cmd_data | output | 64 | Opcode in byte 0, arguments in bytes 1 to 7 |
| cmd_len | output | 4 | Number of bytes kept, 1 to 8 |
| cmd_done | input | 1 | Core pulse that marks the command finished |
| rsp_data | input | 128 | Response buffer, 16 bytes, byte k at bits 8k+7:8k |
| cts | output | 1 | Clear-to-send flag |

## Verification
The assertions assume a well-behaved controller. It changes the data line only while the clock is low, except when it makes START and STOP. It keeps each clock level for several system cycles so the synchroniser sees every edge. It pulses cmd_done only while a command is outstanding. The bench holds each bus half-period for twelve system clocks. It changes data a couple of cycles after a falling clock edge and never during the high phase. It sends a no-acknowledge on the last read byte before its STOP, so the slave never holds the line low when the STOP arrives.

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter logic [6:0] ADDR_LO  = 7'h11,
  parameter logic [6:0] ADDR_HI  = 7'h63,
  parameter int         WR_BYTES = 8,
  parameter int         RD_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_sel,
  input  logic                          scl_in,
  input  logic                          sda_in,
  output logic                          sda_oe,
  output logic                          cmd_valid,
  output logic [8*WR_BYTES-1:0]         cmd_data,
  output logic [$clog2(WR_BYTES+1)-1:0] cmd_len,
  input  logic                          cmd_done,
  input  logic [8*RD_BYTES-1:0]         rsp_data,
  output logic                          cts
);
  localparam int LW = $clog2(WR_BYTES + 1);
  localparam int PW = $clog2(RD_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    rx, tx, nb;
  logic          rw, mack, sel_q;
  logic [LW-1:0] wcnt;
  logic [PW-1:0] rptr;

  wire scl   = scl_q[1];
  wire sda   = sda_q[1];
  wire rise  = scl & ~scl_q[2];
  wire fall  = ~scl & scl_q[2];
  wire start = scl & scl_q[2] & sda_q[2] & ~sda;
  wire stop  = scl & scl_q[2] & ~sda_q[2] & sda;
  wire [6:0] my_addr = sel_q ? ADDR_HI : ADDR_LO;

  always_comb begin
    if (rptr >= PW'(RD_BYTES)) nb = 8'h00;
    else if (rptr == '0)       nb = {cts, rsp_data[6:0]};
    else                       nb = rsp_data[8*rptr +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= addr_sel;
      scl_q <= 3'b111;
      sda_q <= 3'b111;
      st <= S_IDLE;
      cnt <= '0;
      rx <= '0;
      tx <= '0;
      rw <= 1'b0;
      mack <= 1'b0;
      wcnt <= '0;
      rptr <= '0;
      sda_oe <= 1'b0;
      cts <= 1'b1;
      cmd_valid <= 1'b0;
      cmd_data <= '0;
      cmd_len <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
      cmd_valid <= 1'b0;
      if (cmd_done) cts <= 1'b1;
      if (start) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
        wcnt <= '0;
        rptr <= '0;
      end else if (stop) begin
        if (st == S_WR && wcnt != '0) begin
          cmd_valid <= 1'b1;
          cmd_len <= wcnt;
          cts <= 1'b0;
        end
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (rise && st != S_IDLE && st != S_SKIP) begin
        if (cnt < 4'd8) rx <= {rx[6:0], sda};
        if (cnt == 4'd8) mack <= ~sda;
        if (cnt < 4'd9) cnt <= cnt + 4'd1;
      end else if (fall) begin
        case (st)
          S_ADDR:
            if (cnt == 4'd8) begin
              if (rx[7:1] == my_addr) begin
                sda_oe <= 1'b1;
                rw <= rx[0];
              end else st <= S_SKIP;
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (rw) begin
                tx <= nb;
                sda_oe <= ~nb[7];
                rptr <= rptr + 1'b1;
                st <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st <= S_WR;
              end
            end
          S_WR:
            if (cnt == 4'd8) begin
              sda_oe <= 1'b1;
              if (wcnt < LW'(WR_BYTES)) begin
                cmd_data[8*wcnt +: 8] <= rx;
                wcnt <= wcnt + 1'b1;
              end
            end else if (cnt == 4'd9) begin
              sda_oe <= 1'b0;
              cnt <= '0;
            end
          S_RD:
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              tx <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (mack) begin
                tx <= nb;
                sda_oe <= ~nb[7];
                if (rptr < PW'(RD_BYTES)) rptr <= rptr + 1'b1;
              end else begin
                sda_oe <= 1'b0;
                st <= S_SKIP;
              end
            end
          default: ;
        endcase
      end
    end
  end

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);
  assert_oe_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(fall) || $past(start) || $past(stop)));
  assert_cmd_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len >= LW'(1) && cmd_len <= LW'(WR_BYTES)));
  assert_cts_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cts);
  assert_valid_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(stop));
endmodule

// File: tb/sim_twowire_cmd_slave.sv
module sim_twowire_cmd_slave;
  localparam int H = 12;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, addr_sel = 1'b0, cmd_done = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, cmd_valid, cts;
  logic [63:0] cmd_data;
  logic [3:0] cmd_len;
  logic [127:0] rsp_data;
  wire line = m_sda & ~sda_oe;

  twowire_cmd_slave u0 (.clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_in(m_scl),
    .sda_in(line), .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_len(cmd_len), .cmd_done(cmd_done), .rsp_data(rsp_data), .cts(cts));

  int checks = 0, errors = 0, vcount = 0;
  logic [63:0] lat_data;
  logic [3:0] lat_len;
  logic done = 1'b0;

  always @(negedge clk) if (rst_n && cmd_valid) begin
    vcount <= vcount + 1;
    lat_data <= cmd_data;
    lat_len <= cmd_len;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (H) @(negedge clk); endtask
  task automatic bstart(); m_sda = 1; m_scl = 1; hp(); m_sda = 0; hp(); m_scl = 0; hp(); endtask
  task automatic bstop(); m_sda = 0; hp(); m_scl = 1; hp(); m_sda = 1; hp(); endtask
  task automatic bit_out(input logic b);
    m_sda = b; hp(); m_scl = 1; hp(); m_scl = 0; repeat (2) @(negedge clk);
  endtask
  task automatic bit_in(output logic v);
    m_sda = 1; hp(); m_scl = 1; repeat (H/2) @(negedge clk); v = line;
    repeat (H - H/2) @(negedge clk); m_scl = 0; repeat (2) @(negedge clk);
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a); ack = ~a;
  endtask
  task automatic rbyte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin logic v; bit_in(v); b[i] = v; end
    bit_out(~ack);
  endtask
  task automatic pulse_done(); @(negedge clk) cmd_done = 1; @(negedge clk) cmd_done = 0; endtask
  task automatic do_reset(input logic sel);
    rst_n = 0; addr_sel = sel; repeat (10) @(negedge clk); rst_n = 1; repeat (4) @(negedge clk);
  endtask

  localparam logic [67:0] VEC [4] = '{
    {4'd1, 64'h00000000_000000A7},
    {4'd3, 64'h00000000_00C3B2A1},
    {4'd8, 64'h8877_6655_4433_2211},
    {4'd5, 64'h000000FE_DCBA9876}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int base;
    for (int k = 0; k < 16; k++) rsp_data[8*k +: 8] = {k[3:0], ~k[3:0]};
    do_reset(1'b0);
    chk("R1 reset oe", sda_oe, 0);
    chk("R11 reset cts", cts, 1);
    chk("R7 reset valid", cmd_valid, 0);

    for (int v = 0; v < 4; v++) begin
      int n = int'(VEC[v][67:64]);
      base = vcount;
      bstart(); wbyte({7'h11, 1'b0}, ack); chk("R3 R2 ctrl ack", ack, 1);
      for (int i = 0; i < n; i++) begin wbyte(VEC[v][8*i +: 8], ack); chk("R5 data ack", ack, 1); end
      bstop(); repeat (4) @(negedge clk);
      chk("R7 pulse", vcount - base, 1);
      chk("R5 len", lat_len, n);
      for (int i = 0; i < n; i++) chk("R5 byte", lat_data[8*i +: 8], VEC[v][8*i +: 8]);
      chk("R11 cts low", cts, 0);
      pulse_done(); chk("R11 cts high", cts, 1);
    end

    base = vcount;
    bstart(); wbyte(8'h22, ack);
    for (int i = 0; i < 10; i++) begin wbyte(8'h50 + 8'(i), ack); chk("R6 extra ack", ack, 1); end
    bstop(); repeat (4) @(negedge clk);
    chk("R6 len", lat_len, 8);
    chk("R6 data", lat_data[31:0], 32'h53525150);
    chk("R6 data hi", lat_data[63:32], 32'h57565554);
    chk("R6 pulse", vcount - base, 1);
    pulse_done();

    base = vcount;
    bstart(); wbyte(8'h22, ack); bstop(); repeat (4) @(negedge clk);
    chk("R7 addr-only no cmd", vcount - base, 0);

    bstart(); wbyte({7'h22, 1'b0}, ack); chk("R3 mismatch nack", ack, 0);
    wbyte(8'h00, ack); chk("R3 mismatch quiet", ack, 0);
    bstop(); repeat (4) @(negedge clk);
    chk("R7 mismatch no cmd", vcount - base, 0);

    bstart(); wbyte({7'h11, 1'b1}, ack); chk("R2 read ctrl ack", ack, 1);
    for (int k = 0; k < 18; k++) begin
      logic [7:0] e;
      rbyte(k != 17, b);
      e = (k == 0) ? 8'h8F : (k < 16) ? {4'(k), ~4'(k)} : 8'h00;
      if (k < 16) chk("R8 read byte", b, e); else chk("R10 past end", b, e);
    end
    bstop();

    bstart(); wbyte(8'h22, ack); wbyte(8'h3C, ack); bstop();
    bstart(); wbyte(8'h23, ack); rbyte(1'b0, b); chk("R11 status cts clear", b, 8'h0F);
    rbyte(1'b0, b); chk("R9 released after nack", b, 8'hFF);
    bstop();
    pulse_done(); chk("R11 cts after done", cts, 1);

    do_reset(1'b1);
    bstart(); wbyte(8'h22, ack); chk("R4 lo addr rejected", ack, 0); bstop();
    base = vcount;
    bstart(); wbyte({7'h63, 1'b0}, ack); chk("R4 hi addr ack", ack, 1);
    wbyte(8'hA5, ack); bstop(); repeat (4) @(negedge clk);
    chk("R4 cmd", vcount - base, 1);
    chk("R4 opcode", lat_data[7:0], 8'hA5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule